// File: doc/BRIEF.md
# Repair Image Fuse ROM Programmer

This controller moves memory repair state between a serial repair-register chain and a word-wide fuse ROM. In program mode it takes a mask of the memories that were repaired. It switches every other memory's segment out of the chain path and clocks the remaining bits out of the chain. It packs those bits into ROM words behind a header word and writes each word through a simple write port that has a busy handshake. No word needs any outside action.

In load mode it reads the header back and takes the repaired-memory mask from it. It then switches the same segments into the chain path, reads the data words and shifts their bits back in. Unrepaired memories' segments are bypassed and keep their contents. During programming the chain output is fed back to its input, so the repair state held in the chain survives the dump.

The segment length of each memory, the ROM word width, the control field width and the control constant are all parameters.

Top module: `repair_rom_programmer`

## Requirements
- R1: After reset, `done`, `rom_we`, `rom_re` and `chain_shift` are low and `chain_sel` is zero.
- R2: Program mode writes a header at ROM address 0. Bits [C-1:0] hold the control constant `HDR_CTRL`, bits [C+M-1:C] hold the repaired mask (bit k for memory k), and all higher bits are zero.
- R3: In program mode, `chain_sel` equals the mask (bit k selects memory k into the chain path). `chain_shift` pulses exactly once per bit of the selected segments. Chain orientation: `chain_si` enters the top bit of memory 0. `chain_so` is bit 0 of the last selected memory. Each shift moves bits toward bit 0, and a segment's bit 0 passes into the next selected segment's top bit. The bit present on `chain_so` before each shift is packed LSB-first into data words at addresses 1, 2, and so on.
- R4: When the stored bit count is not a multiple of W, the unused high bits of the last data word are zero. When it is a multiple, no extra word is written.
- R5: During program mode `chain_si` carries `chain_so`, so the chain contents are unchanged once programming ends.
- R6: Each `rom_we` or `rom_re` is a single-cycle pulse issued only while `rom_busy` is low. The next access waits until `rom_busy` has dropped. A program run with B stored bits writes exactly 1 + ceil(B/W) words.
- R7: Load mode reads the header, sets `chain_sel` to the stored mask and reads ceil(B/W) data words. It shifts exactly B bits, in stored order, into the selected segments, so that each repaired segment regains the contents it had when it was programmed.
- R8: A zero mask programs only the header and loads only the header, with no chain shift in either mode.
- R9: `done` rises when the last word has been written or the last bit loaded. It stays high until the next accepted start and goes low in the cycle after that start.
- R10: Start requests made while an operation is running are ignored. When both starts arrive together in idle, program mode wins and no ROM read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_prog | input | 1 | Start program mode (pulse) |
| start_load | input | 1 | Start load mode (pulse) |
| repaired_mask | input | M | Repaired memories, sampled at program start |
| chain_sel | output | M | Segment select; a clear bit bypasses that memory |
| chain_shift | output | 1 | Shift enable for the selected chain |
| chain_si | output | 1 | Serial data into the chain |
| chain_so | input | 1 | Serial data out of the chain |
| rom_we | output | 1 | ROM write strobe |
| rom_re | output | 1 | ROM read strobe |
| rom_addr | output | AW | ROM word address |
| rom_wdata | output | W | ROM write data |
| rom_rdata | input | W | ROM read data, valid once busy drops after a read |
| rom_busy | input | 1 | ROM busy |
| done | output | 1 | Operation complete |

## Verification
The bench programs masks that select two separated memories, all memories, the two memories whose lengths add up to exactly one word, and no memory at all. These cases separate segment ordering and bypass from bit ordering inside a segment, padding from the exact-fit case, and the header-only path from the others. The ROM answers with zero, two and three cycles of busy to expose handshake timing faults. Each load follows a matching program into a chain filled with a different pattern, so a restored segment shows up apart from an untouched one. Start pulses sent mid-run and together check that starts are ignored and that program mode has priority.

// File: rtl/repair_rom_programmer.sv
module repair_rom_programmer #(
  parameter int M = 4,
  parameter int W = 8,
  parameter int C = 2,
  parameter int AW = 4,
  parameter logic [8*M-1:0] SEG_LEN = {8'd5, 8'd3, 8'd7, 8'd4},
  parameter logic [C-1:0] HDR_CTRL = 2'b10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_prog,
  input  logic          start_load,
  input  logic [M-1:0]  repaired_mask,
  output logic [M-1:0]  chain_sel,
  output logic          chain_shift,
  output logic          chain_si,
  input  logic          chain_so,
  output logic          rom_we,
  output logic          rom_re,
  output logic [AW-1:0] rom_addr,
  output logic [W-1:0]  rom_wdata,
  input  logic [W-1:0]  rom_rdata,
  input  logic          rom_busy,
  output logic          done
);

  function automatic int sum_all();
    int s = 0;
    for (int k = 0; k < M; k++) s += int'(SEG_LEN[8*k +: 8]);
    return s;
  endfunction

  localparam int TOTAL = sum_all();
  localparam int LW = $clog2(TOTAL + 1);
  localparam int PW = (W > 1) ? $clog2(W) : 1;
  localparam int MAXW = 1 + (TOTAL + W - 1) / W;

  function automatic logic [LW-1:0] bits_of(input logic [M-1:0] m);
    int s = 0;
    for (int k = 0; k < M; k++) if (m[k]) s += int'(SEG_LEN[8*k +: 8]);
    return LW'(s);
  endfunction

  typedef enum logic [2:0] {S_IDLE, S_WR, S_WWAIT, S_PSH, S_RD, S_RWAIT, S_LSH} st_t;

  st_t           st;
  logic [M-1:0]  mask_q;
  logic [LW-1:0] left;
  logic [PW-1:0] pos;
  logic [W-1:0]  wbuf;
  logic [AW-1:0] addr_q;
  logic          hdr_q, done_q;
  logic [M-1:0]  rd_mask;

  assign rd_mask     = rom_rdata[C +: M];
  assign chain_sel   = mask_q;
  assign chain_shift = (st == S_PSH) || (st == S_LSH);
  assign chain_si    = (st == S_LSH) ? wbuf[pos] : chain_so;
  assign rom_we      = (st == S_WR) && !rom_busy;
  assign rom_re      = (st == S_RD) && !rom_busy;
  assign rom_addr    = addr_q;
  assign rom_wdata   = wbuf;
  assign done        = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      mask_q <= '0;
      left <= '0;
      pos <= '0;
      wbuf <= '0;
      addr_q <= '0;
      hdr_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start_prog) begin
            mask_q <= repaired_mask;
            left <= bits_of(repaired_mask);
            wbuf <= W'({repaired_mask, HDR_CTRL});
            addr_q <= '0;
            done_q <= 1'b0;
            st <= S_WR;
          end else if (start_load) begin
            addr_q <= '0;
            hdr_q <= 1'b1;
            done_q <= 1'b0;
            st <= S_RD;
          end
        end
        S_WR: if (!rom_busy) st <= S_WWAIT;
        S_WWAIT: begin
          if (!rom_busy) begin
            addr_q <= addr_q + AW'(1);
            if (left == '0) begin
              done_q <= 1'b1;
              st <= S_IDLE;
            end else begin
              wbuf <= '0;
              pos <= '0;
              st <= S_PSH;
            end
          end
        end
        S_PSH: begin
          wbuf[pos] <= chain_so;
          left <= left - LW'(1);
          pos <= pos + PW'(1);
          if (left == LW'(1) || pos == PW'(W - 1)) st <= S_WR;
        end
        S_RD: if (!rom_busy) st <= S_RWAIT;
        S_RWAIT: begin
          if (!rom_busy) begin
            addr_q <= addr_q + AW'(1);
            wbuf <= rom_rdata;
            pos <= '0;
            if (hdr_q) begin
              hdr_q <= 1'b0;
              mask_q <= rd_mask;
              left <= bits_of(rd_mask);
              if (bits_of(rd_mask) == '0) begin
                done_q <= 1'b1;
                st <= S_IDLE;
              end else begin
                st <= S_RD;
              end
            end else begin
              st <= S_LSH;
            end
          end
        end
        S_LSH: begin
          left <= left - LW'(1);
          pos <= pos + PW'(1);
          if (left == LW'(1)) begin
            done_q <= 1'b1;
            st <= S_IDLE;
          end else if (pos == PW'(W - 1)) begin
            st <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_shift_needs_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chain_shift |-> (chain_sel != '0));
  assert_sel_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chain_shift |=> (chain_shift || done) ? $stable(chain_sel) : 1'b1);
  assert_we_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rom_we |=> !rom_we);
  assert_re_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rom_re |=> !rom_re);
  assert_addr_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_we || rom_re) |-> (int'(rom_addr) < MAXW));
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!chain_shift && !rom_we && !rom_re));

endmodule

// File: tb/repair_rom_programmer_test.sv
module repair_rom_programmer_test;
  localparam int M = 4, W = 8, AW = 4, NB = 19;
  localparam int LEN [4] = '{4, 7, 3, 5};
  localparam int OFF [4] = '{0, 4, 11, 14};

  logic clk = 0, rst_n = 0, start_prog = 0, start_load = 0;
  logic [M-1:0] repaired_mask = '0;
  logic [M-1:0] chain_sel;
  logic chain_shift, chain_si, chain_so, rom_we, rom_re, done;
  logic [AW-1:0] rom_addr;
  logic [W-1:0] rom_wdata, rom_rdata;
  logic rom_busy;

  always #4 clk = ~clk;

  repair_rom_programmer uut (.clk(clk), .rst_n(rst_n), .start_prog(start_prog),
    .start_load(start_load), .repaired_mask(repaired_mask), .chain_sel(chain_sel),
    .chain_shift(chain_shift), .chain_si(chain_si), .chain_so(chain_so),
    .rom_we(rom_we), .rom_re(rom_re), .rom_addr(rom_addr), .rom_wdata(rom_wdata),
    .rom_rdata(rom_rdata), .rom_busy(rom_busy), .done(done));

  int ncmp = 0, nbad = 0, cyc = 0;
  int nwr = 0, nrd = 0, nsh = 0, viol = 0, lat = 0, cnt = 0;
  logic [W-1:0] rom [0:15];
  logic [NB-1:0] chain_v;
  logic [W-1:0] expw [0:7];
  int expn;

  assign rom_busy = (cnt != 0);

  always @(posedge clk) begin
    if (rom_we || rom_re) cnt <= lat;
    else if (cnt > 0) cnt <= cnt - 1;
    if ((rom_we || rom_re) && rom_busy) viol <= viol + 1;
    if (rom_we) begin rom[rom_addr] <= rom_wdata; nwr <= nwr + 1; end
    if (rom_re) begin rom_rdata <= rom[rom_addr]; nrd <= nrd + 1; end
  end

  always_comb begin
    chain_so = 1'b0;
    for (int k = 0; k < M; k++) if (chain_sel[k]) chain_so = chain_v[OFF[k]];
  end

  always @(posedge clk) begin : chain_model
    logic [NB-1:0] nv;
    logic c, o;
    if (chain_shift) begin
      nv = chain_v;
      c = chain_si;
      for (int k = 0; k < M; k++) begin
        if (chain_sel[k]) begin
          o = nv[OFF[k]];
          for (int i = 0; i < LEN[k] - 1; i++) nv[OFF[k]+i] = nv[OFF[k]+i+1];
          nv[OFF[k]+LEN[k]-1] = c;
          c = o;
        end
      end
      chain_v <= nv;
      nsh <= nsh + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nbad = nbad + 1;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  end

  task automatic check(string req, longint act, longint expv);
    ncmp++;
    if (act != expv) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic calc_words(logic [M-1:0] m);
    int n = 0;
    for (int j = 0; j < 8; j++) expw[j] = '0;
    expw[0] = {2'b00, m, 2'b10};
    for (int k = M - 1; k >= 0; k--)
      if (m[k])
        for (int i = 0; i < LEN[k]; i++) begin
          expw[1 + n / W][n % W] = chain_v[OFF[k]+i];
          n++;
        end
    expn = 1 + (n + W - 1) / W;
  endtask

  task automatic clear_counts();
    @(negedge clk);
    nwr = 0; nrd = 0; nsh = 0; viol = 0;
  endtask

  task automatic wait_done(string req);
    int n = 0;
    while (!done && n < 3000) begin @(negedge clk); n++; end
    check(req, done, 1);
  endtask

  task automatic pulse(logic p, logic l, logic [M-1:0] m);
    @(negedge clk);
    repaired_mask = m; start_prog = p; start_load = l;
    @(negedge clk);
    start_prog = 0; start_load = 0;
  endtask

  task automatic do_program(string req, logic [M-1:0] m, int l);
    logic [NB-1:0] saved;
    lat = l;
    clear_counts();
    saved = chain_v;
    calc_words(m);
    pulse(1, 0, m);
    check({req, " R9 done cleared"}, done, 0);
    check({req, " R3 sel"}, chain_sel, m);
    wait_done(req);
    check({req, " R6 writes"}, nwr, expn);
    check({req, " R6 no access while busy"}, viol, 0);
    check({req, " R2 header"}, rom[0], expw[0]);
    for (int j = 1; j < expn; j++) check({req, " R3 R4 data word"}, rom[j], expw[j]);
    check({req, " R5 chain kept"}, chain_v, saved);
  endtask

  task automatic do_load(string req, logic [NB-1:0] image, logic [NB-1:0] fill,
                         logic [M-1:0] m, int l);
    logic [NB-1:0] expc;
    int nbits = 0;
    lat = l;
    expc = fill;
    for (int k = 0; k < M; k++)
      if (m[k]) begin
        nbits += LEN[k];
        for (int i = 0; i < LEN[k]; i++) expc[OFF[k]+i] = image[OFF[k]+i];
      end
    clear_counts();
    chain_v = fill;
    pulse(0, 1, '0);
    wait_done(req);
    check({req, " R7 sel"}, chain_sel, m);
    check({req, " R7 reads"}, nrd, 1 + (nbits + W - 1) / W);
    check({req, " R7 shifts"}, nsh, nbits);
    check({req, " R7 chain restored"}, chain_v, expc);
    check({req, " R6 no access while busy"}, viol, 0);
  endtask

  task automatic t_reset();
    check("R1 done", done, 0);
    check("R1 we", rom_we, 0);
    check("R1 re", rom_re, 0);
    check("R1 shift", chain_shift, 0);
    check("R1 sel", chain_sel, 0);
  endtask

  task automatic t_split();
    logic [NB-1:0] img = 19'h5A3C6;
    chain_v = img;
    do_program("split", 4'b1010, 2);
    check("split R3 shifts", nsh, 12);
    do_load("split", img, 19'h2B1E9, 4'b1010, 3);
  endtask

  task automatic t_all();
    logic [NB-1:0] img = 19'h6D2B5;
    chain_v = img;
    do_program("all R4 pad", 4'b1111, 0);
    check("all R4 pad top", rom[3][7:3], 0);
    do_load("all", img, '0, 4'b1111, 0);
  endtask

  task automatic t_exact();
    chain_v = 19'h31F0E;
    do_program("exact R4", 4'b1100, 1);
    check("exact R4 shifts", nsh, 8);
  endtask

  task automatic t_zero();
    logic [NB-1:0] img = 19'h12345;
    chain_v = img;
    do_program("zero R8", 4'b0000, 2);
    check("zero R8 no shift", nsh, 0);
    do_load("zero R8", img, 19'h7ABCD, 4'b0000, 2);
  endtask

  task automatic t_ignore();
    logic [NB-1:0] img = 19'h4C3A1;
    chain_v = img;
    lat = 2;
    calc_words(4'b1010);
    clear_counts();
    pulse(1, 1, 4'b1010);
    for (int i = 0; i < 6; i++) @(negedge clk);
    pulse(1, 1, 4'b0101);
    wait_done("R10");
    check("R10 priority no read", nrd, 0);
    check("R10 writes", nwr, expn);
    for (int j = 0; j < expn; j++) check("R10 words", rom[j], expw[j]);
    check("R10 sel kept", chain_sel, 4'b1010);
  endtask

  initial begin
    for (int j = 0; j < 16; j++) rom[j] = '0;
    chain_v = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_split();
    t_all();
    t_exact();
    t_zero();
    t_ignore();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule